// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic heart of a signal-processing datapath. Two 16-bit operands go into a signed 17x17 multiplier. The product is widened to the width of an accumulator and then combined with one of two 40-bit accumulators in a single clock. The operation either adds the product, subtracts it, loads it or clears the accumulator. Each accumulator has 8 guard bits above a 32-bit body, so a long run of products can grow past the 1.31 range without losing the sign.

The multiplier has two modes. In fractional mode both operands are Q15 and the result is a left-aligned 1.31 product. In integer mode each operand is independently read as signed or unsigned, which gives signed, unsigned and mixed-sign products. Saturation can be switched on for each operation. When it is on, a result that leaves the 40-bit range is clamped and a sticky flag is raised. A separate overflow flag reports that a value has spread into the guard bits.

Top module: `mac_unit`

## Requirements
- R1: After reset is asserted, both accumulators read zero and all overflow and saturation flags are low.
- R2: When `frac_i`=1, the operands are Q15 and the sign controls are ignored. The product is the signed 16x16 product shifted left by one bit and sign-extended to 40 bits. For example, 0x4000 x 0x4000 gives 0x00_2000_0000.
- R3: In fractional mode, 0x8000 x 0x8000 gives 0x00_7FFF_FFFF, which is the largest positive 1.31 value.
- R4: When `frac_i`=0, the product is an integer product. Operand a is signed when `a_signed_i`=1 and unsigned otherwise, and the same holds for b with `b_signed_i`. The product is sign-extended to 40 bits.
- R5: Operation code 1 (MAC) adds the product to the selected accumulator.
- R6: Operation code 2 (MSC) subtracts the product from the selected accumulator.
- R7: Operation code 3 (MPY) loads the product into the selected accumulator.
- R8: Operation code 4 (CLR) sets the selected accumulator to zero and clears its sticky saturation flag.
- R9: `acc_sel_i`=0 selects accumulator A and 1 selects B. Only the selected accumulator changes. Code 0 and codes 5 to 7 change neither accumulator.
- R10: With `sat_en_i`=1, a MAC or MSC result outside the signed 40-bit range is clamped. A positive overflow gives 0x7F_FFFF_FFFF and a negative one gives 0x80_0000_0000. The sticky saturation flag of that accumulator is set and stays set until CLR.
- R11: With `sat_en_i`=0, the result wraps modulo 2^40 and the sticky flag is not set.
- R12: An accumulator's overflow flag is high exactly when its bits 39..31 are not all equal. This holds whether or not saturation is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 MAC, 2 MSC, 3 MPY, 4 CLR |
| acc_sel_i | input | 1 | Accumulator select: 0 A, 1 B |
| frac_i | input | 1 | 1 = fractional Q15 mode |
| a_signed_i | input | 1 | Operand a is signed (integer mode) |
| b_signed_i | input | 1 | Operand b is signed (integer mode) |
| sat_en_i | input | 1 | Saturation enable for this operation |
| op_a_i | input | 16 | Operand a |
| op_b_i | input | 16 | Operand b |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_a_o | output | 1 | A has spread into its guard bits |
| ovf_b_o | output | 1 | B has spread into its guard bits |
| sat_a_o | output | 1 | Sticky saturation flag of A |
| sat_b_o | output | 1 | Sticky saturation flag of B |

## Verification
The fractional products use positive, mixed-sign and the single -1.0 x -1.0 operand pair. Together they separate a correct one-bit alignment and sign extension from the clamp of the corner case. The integer products reuse the all-ones pattern as signed, unsigned and mixed operands, so each sign control shows up as a different 40-bit result. Long MAC and MSC runs on the largest product push an accumulator across bit 39 with saturation on and then off. These runs tell clamping from wrapping, test the stickiness of the flag and test the guard-bit overflow flag. Short runs on small integers, together with idle and unused operation codes, check add, subtract, load and clear, and check that the accumulator that is not selected is left alone.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int NUM_ACC = 2;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MAC = 3'd1,
    OP_MSC = 3'd2,
    OP_MPY = 3'd3,
    OP_CLR = 3'd4
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic             frac_i,
  input  logic             a_signed_i,
  input  logic             b_signed_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int EXT_W  = OP_W + 1;
  localparam int FULL_W = 2 * EXT_W;
  localparam int FRAC_W = 2 * OP_W;

  logic signed [EXT_W-1:0]  ext_a, ext_b;
  logic signed [FULL_W-1:0] full_p;
  logic [FRAC_W-1:0]        frac_p;
  logic                     both_min;

  // fractional mode forces signed operands
  assign ext_a  = {(frac_i | a_signed_i) & op_a_i[OP_W-1], op_a_i};
  assign ext_b  = {(frac_i | b_signed_i) & op_b_i[OP_W-1], op_b_i};
  assign full_p = ext_a * ext_b;

  assign both_min = (op_a_i == {1'b1, {(OP_W-1){1'b0}}}) &&
                    (op_b_i == {1'b1, {(OP_W-1){1'b0}}});

  always_comb begin
    if (both_min) frac_p = {1'b0, {(FRAC_W-1){1'b1}}};
    else          frac_p = {full_p[FRAC_W-2:0], 1'b0};
  end

  always_comb begin
    if (frac_i) prod_o = {{(ACC_W-FRAC_W){frac_p[FRAC_W-1]}}, frac_p};
    else        prod_o = {{(ACC_W-FULL_W){full_p[FULL_W-1]}}, full_p};
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] prod_i,
  input  logic [2:0]       op_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] nxt_o,
  output logic             sat_hit_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W:0] ext_acc, ext_p, sum;
  logic           wrap;

  assign ext_acc = {acc_i[ACC_W-1], acc_i};
  assign ext_p   = {prod_i[ACC_W-1], prod_i};
  assign sum     = (op_i == OP_MSC) ? ext_acc - ext_p : ext_acc + ext_p;
  assign wrap    = sum[ACC_W] ^ sum[ACC_W-1];

  always_comb begin
    nxt_o     = acc_i;
    sat_hit_o = 1'b0;
    case (op_i)
      OP_MAC, OP_MSC: begin
        if (wrap && sat_en_i) begin
          nxt_o     = sum[ACC_W] ? ACC_MIN : ACC_MAX;
          sat_hit_o = 1'b1;
        end else begin
          nxt_o = sum[ACC_W-1:0];
        end
      end
      OP_MPY:  nxt_o = prod_i;
      OP_CLR:  nxt_o = '0;
      default: nxt_o = acc_i;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2:0]                  op_i,
  input  logic                        acc_sel_i,
  input  logic                        frac_i,
  input  logic                        a_signed_i,
  input  logic                        b_signed_i,
  input  logic                        sat_en_i,
  input  logic [OP_W-1:0]             op_a_i,
  input  logic [OP_W-1:0]             op_b_i,
  output logic [GUARD_W+2*OP_W-1:0]   acc_a_o,
  output logic [GUARD_W+2*OP_W-1:0]   acc_b_o,
  output logic                        ovf_a_o,
  output logic                        ovf_b_o,
  output logic                        sat_a_o,
  output logic                        sat_b_o
);
  localparam int ACC_W = GUARD_W + 2 * OP_W;
  localparam int TOP_W = GUARD_W + 1;   // guard bits plus 1.31 sign

  logic [ACC_W-1:0] prod, acc_cur, acc_nxt;
  logic             sat_hit, upd;
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic             sat_q [NUM_ACC];
  logic             ovf   [NUM_ACC];

  assign upd = (op_i == OP_MAC) || (op_i == OP_MSC) ||
               (op_i == OP_MPY) || (op_i == OP_CLR);

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .frac_i     (frac_i),
    .a_signed_i (a_signed_i),
    .b_signed_i (b_signed_i),
    .prod_o     (prod)
  );

  assign acc_cur = acc_q[acc_sel_i];

  mac_accum #(.ACC_W(ACC_W)) u_accum (
    .acc_i     (acc_cur),
    .prod_i    (prod),
    .op_i      (op_i),
    .sat_en_i  (sat_en_i),
    .nxt_o     (acc_nxt),
    .sat_hit_o (sat_hit)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
        sat_q[g] <= 1'b0;
      end else if (upd && (acc_sel_i == 1'(g))) begin
        acc_q[g] <= acc_nxt;
        if (op_i == OP_CLR) sat_q[g] <= 1'b0;
        else if (sat_hit)   sat_q[g] <= 1'b1;
      end
    end
    assign ovf[g] = (|acc_q[g][ACC_W-1 -: TOP_W]) & ~(&acc_q[g][ACC_W-1 -: TOP_W]);
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign ovf_a_o = ovf[0];
  assign ovf_b_o = ovf[1];
  assign sat_a_o = sat_q[0];
  assign sat_b_o = sat_q[1];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic             acc_sel_i,
  input logic             frac_i,
  input logic             sat_en_i,
  input logic [ACC_W-1:0] acc_a_o,
  input logic [ACC_W-1:0] acc_b_o,
  input logic             ovf_a_o,
  input logic             sat_a_o
);
  logic idle;
  assign idle = (op_i == 3'd0) || (op_i > 3'd4);

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ($stable(acc_a_o) && $stable(acc_b_o))); // R9
  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !acc_sel_i) |=> $stable(acc_b_o)); // R9
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && !acc_sel_i) |=> (acc_a_o == '0 && !sat_a_o)); // R8
  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_a_o && !(op_i == 3'd4 && !acc_sel_i)) |=> sat_a_o); // R10
  AST_NO_SAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_en_i && !sat_a_o) |=> !sat_a_o); // R11
  AST_FRAC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && frac_i && !acc_sel_i) |=> !ovf_a_o); // R2
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(GUARD_W + 2 * OP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .acc_sel_i (acc_sel_i),
  .frac_i    (frac_i),
  .sat_en_i  (sat_en_i),
  .acc_a_o   (acc_a_o),
  .acc_b_o   (acc_b_o),
  .ovf_a_o   (ovf_a_o),
  .sat_a_o   (sat_a_o)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sel = 1'b0, frac = 1'b0, sa = 1'b0, sb = 1'b0, sat_en = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, sat_a, sat_b;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_sel_i(sel), .frac_i(frac),
    .a_signed_i(sa), .b_signed_i(sb), .sat_en_i(sat_en),
    .op_a_i(a), .op_b_i(b), .acc_a_o(acc_a), .acc_b_o(acc_b),
    .ovf_a_o(ovf_a), .ovf_b_o(ovf_b), .sat_a_o(sat_a), .sat_b_o(sat_b)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one operation, applied at negedge, result settled at next negedge
  task automatic do_op(input logic [2:0] o, input logic s, input logic f,
                       input logic xa, input logic xb, input logic se,
                       input logic [15:0] va, input logic [15:0] vb);
    op = o; sel = s; frac = f; sa = xa; sb = xb; sat_en = se; a = va; b = vb;
    @(negedge clk);
    op = 3'd0;
  endtask

  task automatic t_reset();
    chk("R1 acc_a", acc_a, 40'h0);
    chk("R1 acc_b", acc_b, 40'h0);
    chk("R1 flags", {36'h0, ovf_a, ovf_b, sat_a, sat_b}, 40'h0);
  endtask

  task automatic t_frac();
    do_op(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h4000, 16'h4000);
    chk("R2 R7 frac 0.5*0.5", acc_a, 40'h00_2000_0000);
    do_op(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC000, 16'h4000);
    chk("R2 frac -0.5*0.5", acc_a, 40'hFF_E000_0000);
    chk("R12 no ovf negative", {39'h0, ovf_a}, 40'h0);
  endtask

  task automatic t_corner();
    do_op(3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
    chk("R3 -1*-1", acc_b, 40'h00_7FFF_FFFF);
    chk("R9 A untouched", acc_a, 40'hFF_E000_0000);
    chk("R12 no ovf B", {39'h0, ovf_b}, 40'h0);
  endtask

  task automatic t_int();
    do_op(3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0002);
    chk("R4 signed", acc_a, 40'hFF_FFFF_FFFE);
    do_op(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
    chk("R4 unsigned", acc_a, 40'h00_FFFE_0001);
    chk("R12 ovf from guard", {39'h0, ovf_a}, 40'h1);
    do_op(3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
    chk("R4 mixed", acc_a, 40'hFF_FFFF_0001);
  endtask

  task automatic t_mac();
    do_op(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, 16'h0);
    chk("R8 clear", acc_a, 40'h0);
    do_op(3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd100, 16'd3);
    do_op(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd7, 16'd5);
    chk("R5 mac", acc_a, 40'd335);
    do_op(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd10, 16'd10);
    chk("R6 msc", acc_a, 40'd235);
  endtask

  task automatic t_idle();
    do_op(3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd9, 16'd9);
    chk("R9 nop", acc_a, 40'd235);
    do_op(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd9, 16'd9);
    do_op(3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd9, 16'd9);
    chk("R9 unused code A", acc_a, 40'd235);
    chk("R9 unused code B", acc_b, 40'h00_7FFF_FFFF);
  endtask

  task automatic t_sat();
    do_op(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    for (int i = 0; i < 260; i++)
      do_op(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h8000, 16'h8000);
    chk("R10 clamp max", acc_a, 40'h7F_FFFF_FFFF);
    chk("R10 sticky set", {39'h0, sat_a}, 40'h1);
    chk("R12 ovf with sat", {39'h0, ovf_a}, 40'h1);
    do_op(3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1, 16'd1);
    chk("R10 sticky holds", {39'h0, sat_a}, 40'h1);
    do_op(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R8 clr sticky", {39'h0, sat_a}, 40'h0);
    do_op(3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    for (int i = 0; i < 260; i++)
      do_op(3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h8000, 16'h8000);
    chk("R10 clamp min", acc_b, 40'h80_0000_0000);
    chk("R10 sticky B", {39'h0, sat_b}, 40'h1);
    chk("R9 A kept", acc_a, 40'h0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 260; i++)
      do_op(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h8000);
    chk("R11 wrap", acc_a, 40'h81_FFFF_FEFC);
    chk("R11 no sticky", {39'h0, sat_a}, 40'h0);
    chk("R12 ovf no sat", {39'h0, ovf_a}, 40'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_frac();
    t_corner();
    t_int();
    t_mac();
    t_idle();
    t_sat();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule